// File: doc/BRIEF.md
# Mode-Selectable Programmable Frequency Divider

This block is the feedback divider of a frequency synthesizer loop. It is clocked by the oscillator signal to be divided and gives one single-cycle output pulse for every N cycles of that clock. N comes from a divisor word and two mode bits.

There are three modes. In the full-width mode the whole word sets N. In the doubling mode N is twice the word, which is made by a divide-by-two stage after the main counter. In the narrow mode the least significant bit of the divisor sits at a higher position, so the low bits of the word are ignored and the range is small. A programmed value below the minimum of its mode is raised to that minimum. An all-zero divisor field selects the top of the range.

An inhibit input turns the divider off. The divisor word and the mode bits may change at any time. They take effect only when an output period ends, so no output period is ever cut short or stretched.

Top module: `mode_divider`

## Requirements
Default parameters: WORD_W=16, SHIFT=4, FULL_MIN=256, NARROW_MIN=4. The mode inputs are decoded as follows: dbl_i=1 is the doubling mode whatever sp_i is; dbl_i=0 with sp_i=1 is the full-width mode; dbl_i=0 with sp_i=0 is the narrow mode.
- R1: In the narrow mode the period of pulse_o is the value of div_word_i[WORD_W-1:SHIFT]. Bits div_word_i[SHIFT-1:0] have no effect on the period.
- R2: In the full-width mode the period of pulse_o is the value of div_word_i.
- R3: In the doubling mode the period of pulse_o is twice the value of div_word_i. This holds with sp_i at either level.
- R4: A divisor field below the minimum of its mode is treated as that minimum. The minimum is FULL_MIN in the full-width and doubling modes and NARROW_MIN in the narrow mode.
- R5: An all-zero divisor field is treated as the top of the range. The top is 2^WORD_W in the full-width and doubling modes (so the doubled period is 2^(WORD_W+1)) and 2^(WORD_W-SHIFT) in the narrow mode.
- R6: While inhibit_i is 1, pulse_o stays 0. After inhibit_i returns to 0, the first pulse appears N clock cycles after the first rising edge that samples inhibit_i low.
- R7: A change of the divisor word or the mode bits takes effect only at the end of an output period. The period in progress completes with its old length. In the doubling mode both halves of a period use the same length.
- R8: pulse_o is high for exactly one clock cycle per period.
- R9: While rst is 1, pulse_o is 0. After rst falls, the first pulse appears N cycles after the first rising edge that samples rst low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Signal to be divided; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| div_word_i | input | WORD_W | Divisor word, MSB first |
| dbl_i | input | 1 | Doubling-mode select |
| sp_i | input | 1 | Full-width select when doubling is off; 0 selects the narrow mode |
| inhibit_i | input | 1 | Turns the divider off while high |
| pulse_o | output | 1 | One-cycle pulse once per divided period |

## Verification
The assertions assume that the divisor word and mode bits are static during reset and inhibit, so that the working length captured there is the one used afterwards. They also assume every legal length is at least two cycles, which the minimum parameters guarantee. The stimulus changes the divisor and the mode bits only on the falling clock edge just after an observed pulse. That lets the bench predict exactly which period still runs at the old length. The bench uses a reduced configuration so that it can sweep every narrow-mode field and the edges of the full range.

// File: rtl/mode_divider_pkg.sv
package mode_divider_pkg;

    typedef enum logic [1:0] {
        DIV_NARROW = 2'd0,
        DIV_FULL   = 2'd1,
        DIV_DOUBLE = 2'd2
    } div_mode_e;

    typedef struct packed {
        logic dbl;
        logic sp;
    } mode_bits_t;

    function automatic div_mode_e decode_mode(input mode_bits_t b);
        if (b.dbl)
            return DIV_DOUBLE;
        else if (b.sp)
            return DIV_FULL;
        else
            return DIV_NARROW;
    endfunction

    function automatic logic is_wide(input div_mode_e m);
        return m != DIV_NARROW;
    endfunction

    // zero selects the top of the range, small values are raised to the floor
    function automatic int unsigned fit_range(input int unsigned raw,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (raw == 0)
            return hi;
        else if (raw < lo)
            return lo;
        else
            return raw;
    endfunction

endpackage

// File: rtl/ratio_calc.sv
module ratio_calc
    import mode_divider_pkg::*;
#(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned SHIFT      = 4,
    parameter int unsigned FULL_MIN   = 256,
    parameter int unsigned NARROW_MIN = 4,
    parameter int unsigned LEN_W      = WORD_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  div_mode_e         mode_i,
    output logic [LEN_W-1:0]  len_o,
    output logic              dbl_o
);
    localparam int unsigned FULL_TOP   = 1 << WORD_W;
    localparam int unsigned NARROW_TOP = 1 << (WORD_W - SHIFT);

    int unsigned raw_wide;
    int unsigned raw_narrow;
    int unsigned chosen;

    always_comb begin
        raw_wide   = 32'(word_i);
        raw_narrow = 32'(word_i >> SHIFT);
        if (is_wide(mode_i))
            chosen = fit_range(raw_wide, FULL_MIN, FULL_TOP);
        else
            chosen = fit_range(raw_narrow, NARROW_MIN, NARROW_TOP);
        len_o = LEN_W'(chosen);
        dbl_o = (mode_i == DIV_DOUBLE);
    end

    // R4
    narrow_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == DIV_NARROW) |-> (32'(len_o) >= NARROW_MIN && 32'(len_o) <= NARROW_TOP));
    // R5
    wide_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i != DIV_NARROW) |-> (32'(len_o) >= FULL_MIN && 32'(len_o) <= FULL_TOP));

endmodule

// File: rtl/count_core.sv
module count_core #(
    parameter int unsigned LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inh_i,
    input  logic [LEN_W-1:0] nlen_i,
    input  logic             ndbl_i,
    input  logic             last_i,
    output logic             tc_o,
    output logic             dbl_w_o
);
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] wlen_q;
    logic             wdbl_q;
    logic             take_new;

    assign tc_o     = (cnt_q == '0) && !inh_i;
    assign take_new = tc_o && last_i;
    assign dbl_w_o  = wdbl_q;

    always_ff @(posedge clk) begin
        if (rst || inh_i) begin
            wlen_q <= nlen_i;
            wdbl_q <= ndbl_i;
            cnt_q  <= nlen_i - 1'b1;
        end else if (take_new) begin
            wlen_q <= nlen_i;
            wdbl_q <= ndbl_i;
            cnt_q  <= nlen_i - 1'b1;
        end else if (tc_o) begin
            cnt_q  <= wlen_q - 1'b1;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R7
    hold_len_chk: assert property (@(posedge clk) disable iff (rst)
        (!inh_i && !take_new) |=> $stable(wlen_q));
    // R7
    hold_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!inh_i && !take_new) |=> $stable(wdbl_q));
    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < wlen_q);

endmodule

// File: rtl/half_stage.sv
module half_stage (
    input  logic clk,
    input  logic rst,
    input  logic inh_i,
    input  logic tc_i,
    input  logic dbl_w_i,
    output logic last_o,
    output logic pulse_o
);
    logic ph_q;
    logic pulse_q;

    assign last_o  = !dbl_w_i || ph_q;
    assign pulse_o = pulse_q;

    always_ff @(posedge clk) begin
        if (rst || inh_i) begin
            ph_q    <= 1'b0;
            pulse_q <= 1'b0;
        end else if (tc_i) begin
            pulse_q <= last_o;
            ph_q    <= !last_o;
        end else begin
            pulse_q <= 1'b0;
        end
    end

    // R6
    quiet_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        inh_i |=> !pulse_q);
    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);
    // R3
    phase_only_double_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q && !inh_i) |-> dbl_w_i);

endmodule

// File: rtl/mode_divider.sv
module mode_divider
    import mode_divider_pkg::*;
#(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned SHIFT      = 4,
    parameter int unsigned FULL_MIN   = 256,
    parameter int unsigned NARROW_MIN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] div_word_i,
    input  logic              dbl_i,
    input  logic              sp_i,
    input  logic              inhibit_i,
    output logic              pulse_o
);
    localparam int unsigned LEN_W = WORD_W + 1;

    mode_bits_t       mbits;
    div_mode_e        mode;
    logic [LEN_W-1:0] next_len;
    logic             next_dbl;
    logic             tc;
    logic             dbl_w;
    logic             last;

    assign mbits = '{dbl: dbl_i, sp: sp_i};
    assign mode  = decode_mode(mbits);

    ratio_calc #(
        .WORD_W    (WORD_W),
        .SHIFT     (SHIFT),
        .FULL_MIN  (FULL_MIN),
        .NARROW_MIN(NARROW_MIN),
        .LEN_W     (LEN_W)
    ) u_ratio (
        .clk   (clk),
        .rst   (rst),
        .word_i(div_word_i),
        .mode_i(mode),
        .len_o (next_len),
        .dbl_o (next_dbl)
    );

    count_core #(
        .LEN_W(LEN_W)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .inh_i  (inhibit_i),
        .nlen_i (next_len),
        .ndbl_i (next_dbl),
        .last_i (last),
        .tc_o   (tc),
        .dbl_w_o(dbl_w)
    );

    half_stage u_half (
        .clk    (clk),
        .rst    (rst),
        .inh_i  (inhibit_i),
        .tc_i   (tc),
        .dbl_w_i(dbl_w),
        .last_o (last),
        .pulse_o(pulse_o)
    );

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !pulse_o);

endmodule

// File: tb/mode_divider_test.sv
module mode_divider_test;
    localparam int WW = 10;
    localparam int SH = 2;
    localparam int FMIN = 16;
    localparam int NMIN = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [WW-1:0] word = '0;
    logic          dbl = 1'b0;
    logic          sp = 1'b0;
    logic          inh = 1'b0;
    logic          pulse;

    int tests = 0;
    int fails = 0;
    int cur_exp = 0;

    always #10 clk = ~clk;

    mode_divider #(.WORD_W(WW), .SHIFT(SH), .FULL_MIN(FMIN), .NARROW_MIN(NMIN)) uut (
        .clk(clk), .rst(rst), .div_word_i(word), .dbl_i(dbl), .sp_i(sp),
        .inhibit_i(inh), .pulse_o(pulse)
    );

    function automatic int expect_len(input int w, input logic d, input logic s);
        int raw;
        if (d || s) begin
            raw = (w == 0) ? (1 << WW) : ((w < FMIN) ? FMIN : w);
            return d ? 2 * raw : raw;
        end
        raw = w >> SH;
        return (raw == 0) ? (1 << (WW - SH)) : ((raw < NMIN) ? NMIN : raw);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse && n < 5000);
    endtask

    // entered on the negedge that shows a pulse
    task automatic measure(input string tag, input int w, input logic d, input logic s);
        int g1, g2, e;
        e = expect_len(w, d, s);
        word = WW'(w);
        dbl = d;
        sp = s;
        gap(g1);
        check({tag, " R7 old period"}, g1, cur_exp);
        @(negedge clk);
        check({tag, " R8 width"}, int'(pulse), 0);
        g2 = 1;
        while (!pulse && g2 < 5000) begin
            @(negedge clk);
            g2++;
        end
        check(tag, g2, e);
        cur_exp = e;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        int fw [10] = '{0, 1, 15, 16, 17, 31, 100, 511, 777, 1023};
        int dw [6]  = '{0, 3, 16, 40, 300, 1023};
        // R9 reset
        word = WW'(5 << SH);
        repeat (4) @(negedge clk);
        check("R9 low in reset", int'(pulse), 0);
        rst = 1'b0;
        gap(n);
        check("R9 first pulse", n, 5);
        cur_exp = 5;
        // R1 R4 R5 narrow sweep, low bits varied
        for (int f = 0; f < (1 << (WW - SH)); f++)
            measure("R1 narrow", (f << SH) | (f % 4), 1'b0, 1'b0);
        // R2 R4 R5 full-width
        foreach (fw[i])
            measure("R2 full", fw[i], 1'b0, 1'b1);
        // R3 R4 R5 doubling, sp both levels
        foreach (dw[i])
            measure("R3 double", dw[i], 1'b1, 1'(i % 2));
        measure("R7 back to narrow", 9 << SH, 1'b0, 1'b0);
        // R6 inhibit
        word = WW'(100);
        dbl = 1'b0;
        sp = 1'b1;
        inh = 1'b1;
        n = 0;
        repeat (300) begin
            @(negedge clk);
            if (pulse) n++;
        end
        check("R6 quiet while inhibited", n, 0);
        inh = 1'b0;
        gap(n);
        check("R6 first pulse after release", n, 100);
        cur_exp = 100;
        measure("R6 steady after release", 100, 1'b0, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule